// File: doc/BRIEF.md
# Serial Receiver Event Reporter

This block sits behind a serial word deserializer and turns its per-word results into host-facing status. For each received data/command word, and for each received control frame, it issues a one-cycle active-low strobe. The bit-count, parity and sync error indications that come with each event are folded into a two-bit error code that holds its value. A separate flag holds overflow, which occurs when a word arrives before the host has read the previous one from the receive latch.

The block also presents the word-identifier bit of received words. Within a burst it keeps the identifier of the burst's first word until an end-of-burst input closes the burst. An active-low error-clear input resets the error code and the overflow flag. An active-low master reset returns sequencing, strobes and flags to idle. All inputs are sampled on the rising clock edge and all outputs are registered.

Top module: `rx_event_reporter`

## Requirements
- R1: A cycle with `ctrl_ev` high makes `ctrl_stb_n` low for exactly the next cycle. In every other cycle it is high.
- R2: A cycle with `word_ev` high makes `word_stb_n` low for exactly the next cycle. In every other cycle it is high.
- R3: The error code of an event is 2'b00 for no error, 2'b01 for a bit-count error, 2'b10 for a parity error and 2'b11 for a sync error. When several errors come together, sync wins over parity, and parity wins over bit count. The code appears on `err_code` in the cycle after the event.
- R4: A nonzero `err_code` keeps its value, and later errors do not change it, until `err_clr_n` or `rst_n` is sampled low.
- R5: Bit-count and sync errors are recorded for control frames as well as words. `err_parity` is ignored on a cycle with `ctrl_ev` high and `word_ev` low.
- R6: `ovf` becomes 1 after a cycle in which `word_ev` is high while the latch still holds an unread word. The latch is filled by `word_ev` and emptied by `host_rd`. A `host_rd` in the same cycle as the new word counts as a timely read. `ovf` then stays 1.
- R7: `err_clr_n` sampled low clears `err_code` and `ovf` in the next cycle. An error or overflow reported in that same cycle is still recorded.
- R8: `rst_n` sampled low makes both strobes high, `err_code` 2'b00, `ovf` 0 and `wi_out` 0 in the next cycle. It also empties the latch state and closes any burst.
- R9: `wi_out` carries the identifier of a received word (0 = data, 1 = command/interrupt) while that word's strobe is low.
- R10: The first word after reset, or after a cycle with `burst_end` high, opens a burst. `wi_out` keeps that word's identifier until `burst_end` is sampled high. A word sampled together with `burst_end` still belongs to the burst that is closing.
- R11: Error inputs sampled with neither `word_ev` nor `ctrl_ev` high have no effect on `err_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| err_clr_n | input | 1 | Clears error code and overflow, active low |
| word_ev | input | 1 | A data/command word was received |
| ctrl_ev | input | 1 | A control frame was received |
| host_rd | input | 1 | Host read the receive latch |
| err_bitcnt | input | 1 | Bit-count error on this event |
| err_parity | input | 1 | Parity error on this event |
| err_sync | input | 1 | Sync error on this event |
| wi_in | input | 1 | Word-identifier bit of the received word |
| burst_end | input | 1 | Closes the current burst |
| word_stb_n | output | 1 | Word strobe, active low, one cycle |
| ctrl_stb_n | output | 1 | Control frame strobe, active low, one cycle |
| err_code | output | 2 | Encoded error code, held |
| ovf | output | 1 | Receive latch overflow, held |
| wi_out | output | 1 | Word identifier, held for a burst |

## Verification
The block has no parameters, so the bench builds it as it stands, and every behaviour is reachable in a few cycles. Directed sequences cover each error priority combination, parity on a lone control frame, a read arriving in the same cycle as the next word, a clear colliding with a new error, and a burst closed by a word that carries `burst_end`. A behavioural model runs beside the design and is compared on every clock.

// File: rtl/rx_event_reporter.sv
module rx_event_reporter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_clr_n,
  input  logic       word_ev,
  input  logic       ctrl_ev,
  input  logic       host_rd,
  input  logic       err_bitcnt,
  input  logic       err_parity,
  input  logic       err_sync,
  input  logic       wi_in,
  input  logic       burst_end,
  output logic       word_stb_n,
  output logic       ctrl_stb_n,
  output logic [1:0] err_code,
  output logic       ovf,
  output logic       wi_out
);

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_BITS = 2'b01;
  localparam logic [1:0] CODE_PAR  = 2'b10;
  localparam logic [1:0] CODE_SYNC = 2'b11;

  logic       latch_full;
  logic       in_burst;
  logic       wi_hold;
  logic [1:0] ev_code;
  logic       any_ev;
  logic       overrun;

  assign any_ev  = word_ev | ctrl_ev;
  assign overrun = word_ev & latch_full & ~host_rd;
  assign wi_out  = wi_hold;

  always_comb begin
    ev_code = CODE_NONE;
    if (any_ev) begin
      if (err_sync)                 ev_code = CODE_SYNC;
      else if (err_parity & word_ev) ev_code = CODE_PAR;
      else if (err_bitcnt)          ev_code = CODE_BITS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_stb_n <= 1'b1;
      ctrl_stb_n <= 1'b1;
      err_code   <= CODE_NONE;
      ovf        <= 1'b0;
      latch_full <= 1'b0;
      in_burst   <= 1'b0;
      wi_hold    <= 1'b0;
    end else begin
      word_stb_n <= ~word_ev;
      ctrl_stb_n <= ~ctrl_ev;
      latch_full <= word_ev | (latch_full & ~host_rd);
      if (!err_clr_n || err_code == CODE_NONE)
        err_code <= ev_code;
      ovf <= (ovf & err_clr_n) | overrun;
      if (word_ev && !in_burst)
        wi_hold <= wi_in;
      in_burst <= burst_end ? 1'b0 : (in_burst | word_ev);
    end
  end

endmodule

// File: rtl/rx_event_reporter_sva.sv
module rx_event_reporter_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       err_clr_n,
  input logic       word_ev,
  input logic       ctrl_ev,
  input logic       err_bitcnt,
  input logic       err_parity,
  input logic       err_sync,
  input logic       word_stb_n,
  input logic       ctrl_stb_n,
  input logic [1:0] err_code,
  input logic       ovf
);

  a_r1_ctrl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_ev |=> !ctrl_stb_n);
  a_r1_ctrl_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ev |=> ctrl_stb_n);
  a_r2_word_low: assert property (@(posedge clk) disable iff (!rst_n)
    word_ev |=> !word_stb_n);
  a_r2_word_high: assert property (@(posedge clk) disable iff (!rst_n)
    !word_ev |=> word_stb_n);
  a_r3_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((word_ev || ctrl_ev) && err_sync && (err_code == 2'b00 || !err_clr_n))
    |=> err_code == 2'b11);
  a_r4_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'b00 && err_clr_n) |=> $stable(err_code));
  a_r5_ctrl_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_ev && !word_ev && err_parity && !err_sync && !err_bitcnt
     && (err_code == 2'b00 || !err_clr_n)) |=> err_code == 2'b00);
  a_r6_ovf_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && err_clr_n) |=> ovf);
  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (word_stb_n && ctrl_stb_n && err_code == 2'b00 && !ovf));
  a_r11_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_ev && !ctrl_ev && err_code == 2'b00) |=> err_code == 2'b00);

endmodule

bind rx_event_reporter rx_event_reporter_sva sva_i (
  .clk(clk), .rst_n(rst_n), .err_clr_n(err_clr_n), .word_ev(word_ev),
  .ctrl_ev(ctrl_ev), .err_bitcnt(err_bitcnt), .err_parity(err_parity),
  .err_sync(err_sync), .word_stb_n(word_stb_n), .ctrl_stb_n(ctrl_stb_n),
  .err_code(err_code), .ovf(ovf)
);

// File: tb/rx_event_reporter_tb_top.sv
`timescale 1ns/1ps
module rx_event_reporter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0, err_clr_n = 1'b1, word_ev = 1'b0, ctrl_ev = 1'b0;
  logic host_rd = 1'b0, err_bitcnt = 1'b0, err_parity = 1'b0, err_sync = 1'b0;
  logic wi_in = 1'b0, burst_end = 1'b0;
  logic word_stb_n, ctrl_stb_n, ovf, wi_out;
  logic [1:0] err_code;

  int checks = 0, errors = 0;
  bit running = 0;

  always #10 clk = ~clk;

  rx_event_reporter dut_i (
    .clk(clk), .rst_n(rst_n), .err_clr_n(err_clr_n), .word_ev(word_ev),
    .ctrl_ev(ctrl_ev), .host_rd(host_rd), .err_bitcnt(err_bitcnt),
    .err_parity(err_parity), .err_sync(err_sync), .wi_in(wi_in),
    .burst_end(burst_end), .word_stb_n(word_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .err_code(err_code), .ovf(ovf), .wi_out(wi_out)
  );

  // behavioural reference model
  int m_wstb = 1, m_cstb = 1, m_code = 0, m_ovf = 0, m_wi = 0;
  int m_pending = 0, m_burst = 0;

  always @(posedge clk) begin
    int c;
    if (!rst_n) begin
      m_wstb = 1; m_cstb = 1; m_code = 0; m_ovf = 0; m_wi = 0;
      m_pending = 0; m_burst = 0;
    end else begin
      c = 0;
      if (word_ev || ctrl_ev) begin
        if (err_sync) c = 3;
        else if (err_parity && word_ev) c = 2;
        else if (err_bitcnt) c = 1;
      end
      if (!err_clr_n) begin m_code = 0; m_ovf = 0; end
      if (m_code == 0) m_code = c;
      if (word_ev && m_pending != 0 && !host_rd) m_ovf = 1;
      if (host_rd) m_pending = 0;
      if (word_ev) m_pending = 1;
      if (word_ev && m_burst == 0) m_wi = wi_in;
      if (word_ev) m_burst = 1;
      if (burst_end) m_burst = 0;
      m_wstb = word_ev ? 0 : 1;
      m_cstb = ctrl_ev ? 0 : 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (running) begin
      chk("R1 model ctrl_stb_n", ctrl_stb_n, m_cstb);
      chk("R2 model word_stb_n", word_stb_n, m_wstb);
      chk("R4 model err_code", err_code, m_code);
      chk("R6 model ovf", ovf, m_ovf);
      chk("R10 model wi_out", wi_out, m_wi);
    end
  end

  task automatic cyc();
    @(posedge clk); #6;
  endtask

  task automatic idle();
    word_ev = 0; ctrl_ev = 0; host_rd = 0; err_bitcnt = 0; err_parity = 0;
    err_sync = 0; burst_end = 0; err_clr_n = 1;
  endtask

  task automatic word(input bit wi, input bit b, input bit p, input bit s);
    word_ev = 1; wi_in = wi; err_bitcnt = b; err_parity = p; err_sync = s;
    cyc(); idle();
    host_rd = 1; cyc(); idle();
  endtask

  task automatic clear();
    err_clr_n = 0; cyc(); idle();
  endtask

  initial begin
    repeat (2) cyc();
    chk("R8 reset word_stb_n", word_stb_n, 1);
    chk("R8 reset ctrl_stb_n", ctrl_stb_n, 1);
    chk("R8 reset err_code", err_code, 0);
    chk("R8 reset ovf", ovf, 0);
    chk("R8 reset wi_out", wi_out, 0);
    rst_n = 1; running = 1;
    cyc();

    word_ev = 1; wi_in = 1; cyc(); idle();
    chk("R2 word strobe low", word_stb_n, 0);
    chk("R9 wi during strobe", wi_out, 1);
    host_rd = 1; cyc(); idle();
    chk("R2 word strobe back high", word_stb_n, 1);
    burst_end = 1; cyc(); idle();

    ctrl_ev = 1; cyc(); idle();
    chk("R1 ctrl strobe low", ctrl_stb_n, 0);
    chk("R1 word strobe unaffected", word_stb_n, 1);
    cyc();
    chk("R1 ctrl strobe back high", ctrl_stb_n, 1);

    ctrl_ev = 1; err_bitcnt = 1; cyc(); idle();
    chk("R5 ctrl bit count", err_code, 1);
    clear();
    chk("R7 clear code", err_code, 0);
    word(0, 1, 1, 0);
    chk("R3 parity over bit count", err_code, 2);
    clear();
    word(0, 1, 1, 1);
    chk("R3 sync over parity", err_code, 3);
    clear();
    ctrl_ev = 1; err_sync = 1; cyc(); idle();
    chk("R5 ctrl sync", err_code, 3);
    clear();

    ctrl_ev = 1; err_parity = 1; cyc(); idle();
    chk("R5 ctrl parity ignored", err_code, 0);
    err_sync = 1; err_parity = 1; err_bitcnt = 1; cyc(); idle();
    chk("R11 errors without event", err_code, 0);

    word(0, 1, 0, 0);
    word(0, 0, 0, 1);
    chk("R4 first code held", err_code, 1);
    err_clr_n = 0; word_ev = 1; err_sync = 1; host_rd = 1; cyc(); idle();
    chk("R7 error with clear recorded", err_code, 3);
    host_rd = 1; cyc(); idle();
    clear();

    word_ev = 1; cyc(); idle();
    word_ev = 1; host_rd = 1; cyc(); idle();
    chk("R6 read in same cycle no overflow", ovf, 0);
    word_ev = 1; cyc(); idle();
    chk("R6 unread word overflow", ovf, 1);
    host_rd = 1; cyc(); idle();
    cyc();
    chk("R6 overflow held", ovf, 1);
    clear();
    chk("R7 clear overflow", ovf, 0);

    burst_end = 1; cyc(); idle();
    word(1, 0, 0, 0);
    chk("R10 burst first wi", wi_out, 1);
    word(0, 0, 0, 0);
    chk("R10 burst wi held", wi_out, 1);
    word_ev = 1; wi_in = 0; burst_end = 1; cyc(); idle();
    chk("R10 closing word keeps wi", wi_out, 1);
    host_rd = 1; cyc(); idle();
    word(0, 0, 0, 0);
    chk("R10 new burst captures wi", wi_out, 0);

    word_ev = 1; err_sync = 1; cyc(); idle();
    word_ev = 1; wi_in = 1; cyc(); idle();
    chk("R6 overflow before reset", ovf, 1);
    rst_n = 0; running = 0; cyc();
    chk("R8 mid reset err_code", err_code, 0);
    chk("R8 mid reset ovf", ovf, 0);
    chk("R8 mid reset wi_out", wi_out, 0);
    rst_n = 1; running = 1; cyc();
    word_ev = 1; cyc(); idle();
    chk("R8 latch emptied by reset", ovf, 0);
    repeat (3) cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule